// File: doc/BRIEF.md
# Packed Half-Precision Compare-and-Set Unit

This block executes one packed compare-and-set instruction per cycle. It takes a 64-bit instruction word, two 32-bit source words already read from the register file, and one predicate bit already read from the predicate file. Each source word holds two FP16 lanes. Each lane is compared on its own. The lane outcome is folded with the predicate through a selectable logic operation, and each lane then becomes either an all-ones mask or FP16 1.0. The two lanes are merged into one destination word.

Operand A always comes from a register. Operand B comes from a register or from an immediate carried in the instruction. Register and predicate indices are decoded combinationally, so the surrounding pipeline can fetch the sources. The result, its destination index and the decode flags appear one cycle after the instruction is presented.

Top module: `hpair_cmpset`

## Requirements
- R1: The register form is recognised when instr[63:51] equals 13'b0101110100011. B is then taken from src_b, and a valid register-form instruction sets out_wr.
- R2: The immediate form is recognised when instr[63:57] equals 7'b0111110 and instr[55] is 0 (instr[56] is don't-care). B's high lane is {instr[35:28], 8'h00} and its low lane is {instr[27:20], 8'h00}.
- R3: If instr[63:57] equals 7'b0111110 and instr[55] is 1, the constant-operand form is reported through out_unsup. Then out_wr is 0, out_illegal is 0 and out_result is 0.
- R4: Any other word raises out_illegal, with out_wr 0 and out_result 0. A supported form whose combiner field instr[42:41] equals 3 also raises out_illegal.
- R5: A true lane writes 16'h3C00 when the float-select bit is set, and 16'hFFFF when it is clear. The float-select bit is instr[49] in the register form and instr[53] in the immediate form. A false lane writes 16'h0000. Lane 0 is bits 15:0 and lane 1 is bits 31:16.
- R6: In both forms, instr[44] clears the sign of A's lanes and instr[43] then inverts it. In the register form, instr[30] clears the sign of B's lanes and instr[31] then inverts it. Immediate B is never modified, so instr[56] has no effect there.
- R7: The condition instr[48:45] works as follows. Bit 0 accepts less-than, bit 1 accepts equal and bit 2 accepts greater-than. If either operand is NaN, the lane outcome is bit 3 (0 for ordered, 1 for unordered). +0 and -0 compare equal.
- R8: The predicate term is pred_in XOR instr[40]. It joins each lane outcome by AND when instr[42:41] is 0, by OR when it is 1, and by XOR when it is 2.
- R9: rd_a_idx is instr[15:8], rd_b_idx is instr[27:20] and pred_idx is instr[39:37], all combinational. out_dst is the registered instr[7:0].
- R10: out_valid follows in_valid by exactly one cycle. After reset all outputs are 0. With out_valid low, out_wr, out_illegal, out_unsup and out_result are 0.
- R11: The flush bit (instr[50] in the register form, instr[54] in the immediate form) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 64 | Instruction word |
| src_a | input | 32 | Operand A, two FP16 lanes |
| src_b | input | 32 | Operand B register value, two FP16 lanes |
| pred_in | input | 1 | Value of the selected predicate |
| rd_a_idx | output | 8 | Register index of A |
| rd_b_idx | output | 8 | Register index of B |
| pred_idx | output | 3 | Predicate index |
| out_valid | output | 1 | Result cycle marker |
| out_wr | output | 1 | Destination write enable |
| out_illegal | output | 1 | Unrecognised instruction |
| out_unsup | output | 1 | Constant-operand form, unsupported |
| out_dst | output | 8 | Destination register index |
| out_result | output | 32 | Packed result word |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle valid timing and that the three outcome flags are mutually exclusive. It checks that each written lane holds only 0, 16'h3C00 or 16'hFFFF, and that both lanes of one word never mix the two true encodings. It also checks that the destination index tracks the previous instruction and that nothing is asserted without out_valid. The numerical outcome of each lane can only be shown by the bench scenarios. These cover signed-zero equality, NaN under ordered and unordered conditions, the order in which the sign modifiers act, the combiner choices, and the invariance to the flush bit and to the immediate-form B negate bit.

// File: rtl/hpair_cmpset.sv
module hpair_cmpset #(
  parameter int LANE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic        pred_in,
  output logic [7:0]  rd_a_idx,
  output logic [7:0]  rd_b_idx,
  output logic [2:0]  pred_idx,
  output logic        out_valid,
  output logic        out_wr,
  output logic        out_illegal,
  output logic        out_unsup,
  output logic [7:0]  out_dst,
  output logic [31:0] out_result
);
  localparam int LANES = 2;
  localparam logic [LANE_W-1:0] ONE_H = 16'h3C00;

  function automatic logic [LANE_W-1:0] apply_mod(input logic [LANE_W-1:0] x,
                                                   input logic clr, input logic flip);
    return {(x[LANE_W-1] & ~clr) ^ flip, x[LANE_W-2:0]};
  endfunction

  function automatic logic cmp_half(input logic [LANE_W-1:0] a, input logic [LANE_W-1:0] b,
                                    input logic [3:0] c);
    logic a_nan, b_nan, zz, lt, gt, eq;
    logic [LANE_W-1:0] ka, kb;
    a_nan = (&a[14:10]) && (|a[9:0]);
    b_nan = (&b[14:10]) && (|b[9:0]);
    zz    = (a[14:0] == 15'd0) && (b[14:0] == 15'd0);
    ka    = a[15] ? ~a : {1'b1, a[14:0]};
    kb    = b[15] ? ~b : {1'b1, b[14:0]};
    eq    = zz || (ka == kb);
    lt    = !eq && (ka < kb);
    gt    = !eq && !lt;
    if (a_nan || b_nan) return c[3];
    return (lt & c[0]) | (eq & c[1]) | (gt & c[2]);
  endfunction

  logic is_reg, is_half, is_imm, is_cb, legal, bf, pterm;
  logic [1:0] comb;
  logic [LANES-1:0] hit;
  logic [31:0] res;
  logic [LANE_W-1:0] lane_v [LANES];
  logic unused_bits;

  assign is_reg  = instr[63:51] == 13'b0101110100011;
  assign is_half = instr[63:57] == 7'b0111110;
  assign is_imm  = is_half && !instr[55];
  assign is_cb   = is_half && instr[55];
  assign comb    = instr[42:41];
  assign legal   = (is_reg || is_imm) && (comb != 2'd3);
  assign bf      = is_reg ? instr[49] : instr[53];
  assign pterm   = pred_in ^ instr[40];

  assign rd_a_idx = instr[15:8];
  assign rd_b_idx = instr[27:20];
  assign pred_idx = instr[39:37];

  assign unused_bits = ^{instr[50], instr[36], instr[19:16]};

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] a_op, b_op, imm_v;
    logic c_out;
    assign imm_v = {instr[20+8*ln +: 8], 8'h00};
    assign a_op  = apply_mod(src_a[LANE_W*ln +: LANE_W], instr[44], instr[43]);
    assign b_op  = is_reg ? apply_mod(src_b[LANE_W*ln +: LANE_W], instr[30], instr[31]) : imm_v;
    assign c_out = cmp_half(a_op, b_op, instr[48:45]);
    always_comb begin
      case (comb)
        2'd0:    hit[ln] = c_out & pterm;
        2'd1:    hit[ln] = c_out | pterm;
        default: hit[ln] = c_out ^ pterm;
      endcase
    end
    assign lane_v[ln] = hit[ln] ? (bf ? ONE_H : {LANE_W{1'b1}}) : '0;
  end

  assign res = {lane_v[1], {LANE_W{1'b0}}} | {{LANE_W{1'b0}}, lane_v[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr      <= 1'b0;
      out_illegal <= 1'b0;
      out_unsup   <= 1'b0;
      out_dst     <= '0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wr      <= in_valid && legal;
      out_illegal <= in_valid && !is_cb && !legal;
      out_unsup   <= in_valid && is_cb;
      out_dst     <= in_valid ? instr[7:0] : 8'd0;
      out_result  <= (in_valid && legal) ? res : 32'd0;
    end
  end
endmodule

module hpair_cmpset_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] instr,
  input logic        out_valid,
  input logic        out_wr,
  input logic        out_illegal,
  input logic        out_unsup,
  input logic [7:0]  out_dst,
  input logic [31:0] out_result
);
  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wr && !out_illegal && !out_unsup && out_result == 32'd0));
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_wr, out_illegal, out_unsup}));
  a_r3_no_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr |-> out_result == 32'd0);
  a_r5_lane_codes: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> ((out_result[15:0] == 16'h0 || out_result[15:0] == 16'h3C00 ||
                 out_result[15:0] == 16'hFFFF) &&
                (out_result[31:16] == 16'h0 || out_result[31:16] == 16'h3C00 ||
                 out_result[31:16] == 16'hFFFF)));
  a_r5_no_mix: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> !((out_result[15:0] == 16'h3C00 && out_result[31:16] == 16'hFFFF) ||
                 (out_result[15:0] == 16'hFFFF && out_result[31:16] == 16'h3C00)));
  a_r9_dst_follow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dst == $past(instr[7:0]));
endmodule

bind hpair_cmpset hpair_cmpset_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .out_valid(out_valid), .out_wr(out_wr), .out_illegal(out_illegal),
  .out_unsup(out_unsup), .out_dst(out_dst), .out_result(out_result)
);

// File: tb/test_hpair_cmpset.sv
module test_hpair_cmpset;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, pred_in = 1'b0;
  logic [63:0] instr = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [7:0] rd_a_idx, rd_b_idx, out_dst;
  logic [2:0] pred_idx;
  logic out_valid, out_wr, out_illegal, out_unsup;
  logic [31:0] out_result;

  int total = 0, bad = 0;
  bit have_prev = 0;
  bit e_valid, e_wr, e_ill, e_uns;
  logic [7:0] e_dst;
  logic [31:0] e_res;
  string e_tag;

  always #2 clk = ~clk;

  hpair_cmpset i_hpair_cmpset (.*);

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic bit is_nan(logic [15:0] h);
    return h[14:10] == 5'd31 && h[9:0] != 0;
  endfunction

  function automatic real h2r(logic [15:0] h);
    int e = h[14:10];
    int m = h[9:0];
    real r;
    if (e == 0) r = m / 16777216.0;
    else if (e == 31) r = 1.0e9;
    else r = (1024 + m) * (2.0 ** (e - 25));
    return h[15] ? -r : r;
  endfunction

  function automatic bit cond_ok(logic [15:0] a, logic [15:0] b, logic [3:0] c);
    real x = h2r(a), y = h2r(b);
    if (is_nan(a) || is_nan(b)) return c[3];
    case (c[2:0])
      3'd1: return x < y;
      3'd2: return x == y;
      3'd3: return x <= y;
      3'd4: return x > y;
      3'd5: return x != y;
      3'd6: return x >= y;
      3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] sgn(logic [15:0] x, bit ab, bit ng);
    logic [15:0] y = x;
    if (ab) y[15] = 1'b0;
    if (ng) y[15] = ~y[15];
    return y;
  endfunction

  task automatic model(logic [63:0] w, logic [31:0] a, logic [31:0] b, bit p);
    bit rf = w[63:51] == 13'b0101110100011;
    bit hf = w[63:57] == 7'b0111110;
    bit im = hf && !w[55];
    int cmb = w[42:41];
    e_valid = 1; e_dst = w[7:0]; e_res = 0;
    e_uns = hf && w[55];
    e_wr = (rf || im) && cmb != 3;
    e_ill = !e_uns && !e_wr;
    if (e_wr) begin
      for (int i = 0; i < 2; i++) begin
        logic [15:0] av = sgn(a[16*i +: 16], w[44], w[43]);
        logic [15:0] bv = rf ? sgn(b[16*i +: 16], w[30], w[31])
                             : {(i == 1 ? w[35:28] : w[27:20]), 8'h00};
        bit q = p ^ w[40];
        bit c = cond_ok(av, bv, w[48:45]);
        bit r = (cmb == 0) ? (c && q) : (cmb == 1) ? (c || q) : (c != q);
        bit f = rf ? w[49] : w[53];
        if (r) e_res[16*i +: 16] = f ? 16'h3C00 : 16'hFFFF;
      end
    end
  endtask

  task automatic compare_prev();
    if (have_prev) begin
      chk(e_tag, "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
      chk(e_tag, "out_wr", {31'd0, out_wr}, {31'd0, e_wr});
      chk(e_tag, "out_illegal", {31'd0, out_illegal}, {31'd0, e_ill});
      chk(e_tag, "out_unsup", {31'd0, out_unsup}, {31'd0, e_uns});
      chk(e_tag, "out_dst", {24'd0, out_dst}, {24'd0, e_dst});
      chk(e_tag, "out_result", out_result, e_res);
    end
  endtask

  task automatic issue(logic [63:0] w, logic [31:0] a, logic [31:0] b, bit p, string tag);
    @(negedge clk);
    compare_prev();
    instr = w; src_a = a; src_b = b; pred_in = p; in_valid = 1'b1;
    model(w, a, b, p);
    e_tag = tag; have_prev = 1;
    #1;
    chk("R9", "rd_a_idx", {24'd0, rd_a_idx}, {24'd0, w[15:8]});
    chk("R9", "rd_b_idx", {24'd0, rd_b_idx}, {24'd0, w[27:20]});
    chk("R9", "pred_idx", {29'd0, pred_idx}, {29'd0, w[39:37]});
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    compare_prev();
    in_valid = 1'b0; instr = '0;
    e_valid = 0; e_wr = 0; e_ill = 0; e_uns = 0; e_dst = 0; e_res = 0;
    e_tag = tag; have_prev = 1;
  endtask

  function automatic logic [63:0] fld(logic [63:0] top, int dst, int ra, int rb,
      int cnd, int cmb, int npred, int pidx, int bfb, int bfv);
    logic [63:0] w = top;
    w[7:0] = dst; w[15:8] = ra; w[27:20] = rb;
    w[48:45] = cnd; w[42:41] = cmb; w[40] = npred[0]; w[39:37] = pidx;
    w[bfb] = bfv[0];
    return w;
  endfunction

  localparam logic [63:0] REG_T = {13'b0101110100011, 51'd0};
  localparam logic [63:0] IMM_T = {7'b0111110, 57'd0};

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10", "reset result", out_result, 32'd0);
    chk("R10", "reset dst", {24'd0, out_dst}, 32'd0);
    rst_n = 1'b1;
    // R1 register form, less-than
    issue(fld(REG_T, 5, 1, 2, 1, 0, 0, 3, 49, 0), 32'h3C00_4000, 32'h4000_3C00, 1, "R1");
    // R5 float-select
    issue(fld(REG_T, 6, 1, 2, 1, 0, 0, 3, 49, 1), 32'h3C00_4000, 32'h4000_3C00, 1, "R5");
    issue(fld(REG_T, 7, 1, 2, 6, 0, 0, 0, 49, 1), 32'h3C00_4000, 32'h3C00_4000, 1, "R5");
    // R2 immediate form: hi byte 0x40 (2.0), lo byte 0x3C (1.0)
    w = fld(IMM_T, 9, 4, 0, 2, 0, 0, 1, 53, 0); w[35:28] = 8'h40; w[27:20] = 8'h3C;
    issue(w, 32'h4000_3C00, 32'hFFFF_FFFF, 1, "R2");
    w[53] = 1; w[48:45] = 4'd4;
    issue(w, 32'h4200_3C00, 32'h0, 1, "R2");
    // R6 immediate ignores bit 56
    w[56] = 1; issue(w, 32'h4200_3C00, 32'h0, 1, "R6");
    // R11 flush bit has no effect
    w[54] = 1; issue(w, 32'h4200_3C00, 32'h0, 1, "R11");
    w = fld(REG_T, 1, 1, 2, 1, 0, 0, 0, 49, 0); w[50] = 1;
    issue(w, 32'h3C00_4000, 32'h4000_3C00, 1, "R11");
    // R3 constant-operand form
    w = fld(IMM_T, 3, 1, 2, 2, 0, 0, 0, 53, 0); w[55] = 1;
    issue(w, 32'h0, 32'h0, 1, "R3");
    // R4 unknown word and reserved combiner
    issue(64'h1234_5678_9ABC_DEF0, 32'h0, 32'h0, 1, "R4");
    issue(fld(REG_T, 2, 1, 2, 2, 3, 0, 0, 49, 0), 32'h0, 32'h0, 1, "R4");
    // R7 signed zeros equal, NaN ordered and unordered
    issue(fld(REG_T, 4, 0, 0, 2, 0, 0, 0, 49, 0), 32'h8000_0000, 32'h0000_8000, 1, "R7");
    issue(fld(REG_T, 4, 0, 0, 5, 0, 0, 0, 49, 0), 32'h7E00_3C00, 32'h3C00_7C01, 1, "R7");
    issue(fld(REG_T, 4, 0, 0, 13, 0, 0, 0, 49, 0), 32'h7E00_3C00, 32'h3C00_7C01, 1, "R7");
    issue(fld(REG_T, 4, 0, 0, 1, 0, 0, 0, 49, 0), 32'hC000_BC00, 32'hBC00_C000, 1, "R7");
    issue(fld(REG_T, 4, 0, 0, 4, 0, 0, 0, 49, 0), 32'h7C00_FC00, 32'h7BFF_FBFF, 1, "R7");
    // R6 modifiers: abs then negate on A, register B modifiers
    w = fld(REG_T, 8, 0, 0, 2, 0, 0, 0, 49, 0); w[44] = 1; w[43] = 1;
    issue(w, 32'h3C00_BC00, 32'hBC00_BC00, 1, "R6");
    w = fld(REG_T, 8, 0, 0, 2, 0, 0, 0, 49, 0); w[30] = 1;
    issue(w, 32'h3C00_BC00, 32'hBC00_BC00, 1, "R6");
    w[31] = 1; issue(w, 32'hBC00_3C00, 32'h3C00_3C00, 1, "R6");
    // R8 combiners and inverted predicate
    issue(fld(REG_T, 1, 0, 0, 1, 0, 1, 0, 49, 0), 32'h3C00_4000, 32'h4000_3C00, 0, "R8");
    issue(fld(REG_T, 1, 0, 0, 1, 1, 0, 0, 49, 0), 32'h3C00_4000, 32'h4000_3C00, 0, "R8");
    issue(fld(REG_T, 1, 0, 0, 1, 1, 1, 0, 49, 0), 32'h3C00_4000, 32'h4000_3C00, 0, "R8");
    issue(fld(REG_T, 1, 0, 0, 1, 2, 0, 0, 49, 0), 32'h3C00_4000, 32'h4000_3C00, 1, "R8");
    // R10 gap then back-to-back
    idle("R10"); idle("R10");
    issue(fld(REG_T, 9, 0, 0, 7, 0, 0, 0, 49, 0), 32'h0, 32'h0, 1, "R10");
    idle("R10");
    // R9 index fields over varied words
    issue(fld(REG_T, 255, 170, 85, 2, 0, 0, 7, 49, 0), 32'h1, 32'h1, 1, "R9");
    for (int k = 0; k < 400; k++) begin
      logic [63:0] r = {$urandom, $urandom};
      case (k % 4)
        0: r[63:51] = REG_T[63:51];
        1: begin r[63:57] = IMM_T[63:57]; r[55] = 0; end
        2: r[63:51] = REG_T[63:51];
        default: ;
      endcase
      issue(r, $urandom, $urandom, $urandom % 2, "R7");
      if (k % 13 == 0) idle("R10");
    end
    idle("R10");
    idle("R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule